// File: doc/BRIEF.md
# Event Counter Bank with Word-Serial Readout

The block holds a bank of 32-bit event counters, one per event strobe coming from a processor core and its cache (instruction decodes, vector fetches, interrupts, program-counter loads, cycles spent in each privilege mode, cache reads, writes, hits and memory traffic, and internal bus reads and writes). Every counter adds one in each clock cycle in which its strobe is high, but only while the bank is running. Software starts and stops the whole bank, and can zero it, with commands written to a control register.

Software reads the counters through one 16-bit data register. A read pointer selects a counter and a half. A load command sets the counter index and an auto-step flag, and always points at the low half. With auto-step on, reading 2N data words in a row returns N consecutive counters, low half first. When the low half is read, the high half is frozen, so a counter that is still running reads back as one consistent 32-bit value.

Top module: `evtcnt_bank`

## Requirements
- R1: After reset every counter is zero, the bank is stopped, and the status register reads 0 (pointer at counter 0, low half, auto-step off).
- R2: Writing to register address 0 issues a command, taken from bits [1:0]: 00 zeroes all counters, 01 starts counting, 10 stops counting, 11 loads the pointer.
- R3: While running, a counter adds exactly one for each cycle in which its strobe is high. Counting takes effect from the cycle after the start write, and ends after the cycle of the stop write. While stopped, strobes leave every counter unchanged.
- R4: The zero command clears every counter to exactly zero and leaves the run state unchanged. A bank that was running keeps counting from zero.
- R5: The load command takes the counter index from bits [6:2] and the auto-step flag from bit 7, and selects the low half. The status register at address 1 shows the index in bits [4:0], the half select in bit 5 (0 low, 1 high) and auto-step in bit 6.
- R6: A read of the data register at address 2 returns bits [15:0] of the selected counter when the low half is selected, and the upper 16 bits when the high half is selected.
- R7: With auto-step on, each data read moves the pointer from the low half to the high half of the same counter, and from the high half to the low half of the next counter.
- R8: With auto-step off, data reads leave the pointer unchanged, and repeated reads return the same word.
- R9: A data read of a low half captures that counter's upper 16 bits in the same cycle. A following read of the high half returns this captured value, even if the counter carried into its upper half in between.
- R10: An auto-step read of the high half of the last counter moves the pointer to counter 0, low half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe; has side effects on the data register |
| regAddr | input | 2 | Register select: 0 control, 1 status, 2 data |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Read data, combinational from regAddr |
| evtStrobe | input | 32 | One-cycle event strobes, one per counter |

## Verification
A wrong run flag shows up at the first data read after a burst of strobes, as counts that are too high or too low. A counter that is not zeroed shows up at the first readout after a zero command. A pointer that steps wrongly shows up in the status register in the cycle after the faulty read, and as values taken from the wrong counter or half. An upper half that is not frozen can only be seen when the low half carries between the two reads, so the bench places the low-half read on a count of 0xFFFF. The error then shows up in the very next data word.

// File: rtl/evtcnt_pkg.sv
package evtcnt_pkg;

  typedef enum logic [1:0] {
    FN_CLR = 2'b00,
    FN_STA = 2'b01,
    FN_STO = 2'b10,
    FN_LOA = 2'b11
  } cmdFunc_e;

  localparam logic [1:0] REG_CTL  = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_DATA = 2'd2;

  // bit positions inside the control word
  localparam int FN_LSB   = 0;
  localparam int ADDR_LSB = 2;
  localparam int AINC_BIT = 7;
  // bit positions inside the status word
  localparam int STAT_HIGH_BIT = 5;
  localparam int STAT_AINC_BIT = 6;

  // suggested strobe assignment
  localparam int EV_KM_PRI0  = 0;
  localparam int EV_KM_PRIX  = 1;
  localparam int EV_KM_WAIT  = 2;
  localparam int EV_SUPER    = 3;
  localparam int EV_USER     = 4;
  localparam int EV_IDECODE  = 5;
  localparam int EV_VECFETCH = 6;
  localparam int EV_IRQ      = 7;
  localparam int EV_PCLOAD   = 8;
  localparam int EV_C_RD     = 9;
  localparam int EV_C_WR     = 10;
  localparam int EV_C_RDHIT  = 11;
  localparam int EV_C_WRHIT  = 12;
  localparam int EV_C_RDMEM  = 13;
  localparam int EV_C_WRMEM  = 14;
  localparam int EV_IB_RD    = 15;
  localparam int EV_IB_WR    = 16;

  typedef struct packed {
    logic run;
    logic clrAll;
    logic captureHi;
  } dpCmd_t;

endpackage

// File: rtl/evtcnt_ctrl.sv
module evtcnt_ctrl
  import evtcnt_pkg::*;
#(
  parameter int NUM_CNT = 32,
  parameter int DATA_W  = 16,
  localparam int AW     = $clog2(NUM_CNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              regRe,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output dpCmd_t            cmd,
  output logic [AW-1:0]     ptrAddr,
  output logic              ptrHigh,
  output logic [DATA_W-1:0] statusWord
);

  localparam logic [AW-1:0] LAST_IDX = AW'(NUM_CNT - 1);

  logic     ctlWr;
  logic     dataRd;
  cmdFunc_e func;
  logic     runQ;
  logic     aincQ;

  assign ctlWr  = regWe && (regAddr == REG_CTL);
  assign dataRd = regRe && (regAddr == REG_DATA);
  assign func   = cmdFunc_e'(regWdata[FN_LSB +: 2]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ <= 1'b0;
    end else if (ctlWr && func == FN_STA) begin
      runQ <= 1'b1;
    end else if (ctlWr && func == FN_STO) begin
      runQ <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrAddr <= '0;
      ptrHigh <= 1'b0;
      aincQ   <= 1'b0;
    end else if (ctlWr && func == FN_LOA) begin
      ptrAddr <= regWdata[ADDR_LSB +: AW];
      ptrHigh <= 1'b0;
      aincQ   <= regWdata[AINC_BIT];
    end else if (dataRd && aincQ) begin
      if (!ptrHigh) begin
        ptrHigh <= 1'b1;
      end else begin
        ptrHigh <= 1'b0;
        ptrAddr <= (ptrAddr == LAST_IDX) ? '0 : ptrAddr + 1'b1;
      end
    end
  end

  always_comb begin
    cmd.run       = runQ;
    cmd.clrAll    = ctlWr && (func == FN_CLR);
    cmd.captureHi = dataRd && !ptrHigh;
  end

  always_comb begin
    statusWord                = '0;
    statusWord[AW-1:0]        = ptrAddr;
    statusWord[STAT_HIGH_BIT] = ptrHigh;
    statusWord[STAT_AINC_BIT] = aincQ;
  end

  a_r3_start_sets_run : assert property (@(posedge clk) disable iff (!rstN)
    (ctlWr && func == FN_STA) |=> runQ);
  a_r3_stop_clears_run : assert property (@(posedge clk) disable iff (!rstN)
    (ctlWr && func == FN_STO) |=> !runQ);
  a_r4_clear_keeps_run : assert property (@(posedge clk) disable iff (!rstN)
    (ctlWr && func == FN_CLR) |=> (runQ == $past(runQ)));
  a_r5_load_low_half : assert property (@(posedge clk) disable iff (!rstN)
    (ctlWr && func == FN_LOA) |=> !ptrHigh);
  a_r8_pointer_holds : assert property (@(posedge clk) disable iff (!rstN)
    (dataRd && !aincQ && !ctlWr) |=> ($stable(ptrAddr) && $stable(ptrHigh)));
  a_r7_low_to_high : assert property (@(posedge clk) disable iff (!rstN)
    (dataRd && aincQ && !ptrHigh && !ctlWr) |=> (ptrHigh && $stable(ptrAddr)));
  a_r10_last_wraps : assert property (@(posedge clk) disable iff (!rstN)
    (dataRd && aincQ && ptrHigh && ptrAddr == LAST_IDX && !ctlWr) |=> (ptrAddr == '0 && !ptrHigh));

endmodule

// File: rtl/evtcnt_datapath.sv
module evtcnt_datapath
  import evtcnt_pkg::*;
#(
  parameter int NUM_CNT = 32,
  parameter int DATA_W  = 16,
  localparam int AW     = $clog2(NUM_CNT),
  localparam int CNT_W  = 2 * DATA_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCmd_t             cmd,
  input  logic [AW-1:0]      ptrAddr,
  input  logic               ptrHigh,
  input  logic [NUM_CNT-1:0] evt,
  output logic [DATA_W-1:0]  dataWord
);

  logic [CNT_W-1:0]  cntQ [NUM_CNT];
  logic [DATA_W-1:0] holdHi;
  logic [CNT_W-1:0]  selCnt;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cntQ[i] <= '0;
      end else if (cmd.clrAll) begin
        cntQ[i] <= '0;
      end else if (cmd.run && evt[i]) begin
        cntQ[i] <= cntQ[i] + 1'b1;
      end
    end

    a_r4_counter_zeroed : assert property (@(posedge clk) disable iff (!rstN)
      cmd.clrAll |=> (cntQ[i] == '0));
    a_r3_counter_frozen : assert property (@(posedge clk) disable iff (!rstN)
      (!cmd.run && !cmd.clrAll) |=> $stable(cntQ[i]));
    a_r3_counter_steps : assert property (@(posedge clk) disable iff (!rstN)
      (cmd.run && evt[i] && !cmd.clrAll) |=> (cntQ[i] == CNT_W'($past(cntQ[i]) + 1)));
  end

  assign selCnt = cntQ[ptrAddr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdHi <= '0;
    end else if (cmd.captureHi) begin
      holdHi <= selCnt[CNT_W-1:DATA_W];
    end
  end

  assign dataWord = ptrHigh ? holdHi : selCnt[DATA_W-1:0];

  a_r9_high_captured : assert property (@(posedge clk) disable iff (!rstN)
    cmd.captureHi |=> (holdHi == $past(selCnt[CNT_W-1:DATA_W])));

endmodule

// File: rtl/evtcnt_bank.sv
module evtcnt_bank
  import evtcnt_pkg::*;
#(
  parameter int NUM_CNT = 32,
  parameter int DATA_W  = 16,
  localparam int AW     = $clog2(NUM_CNT)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic               regRe,
  input  logic [1:0]         regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  input  logic [NUM_CNT-1:0] evtStrobe
);

  dpCmd_t            cmd;
  logic [AW-1:0]     ptrAddr;
  logic              ptrHigh;
  logic [DATA_W-1:0] statusWord;
  logic [DATA_W-1:0] dataWord;

  evtcnt_ctrl #(.NUM_CNT(NUM_CNT), .DATA_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regWe      (regWe),
    .regRe      (regRe),
    .regAddr    (regAddr),
    .regWdata   (regWdata),
    .cmd        (cmd),
    .ptrAddr    (ptrAddr),
    .ptrHigh    (ptrHigh),
    .statusWord (statusWord)
  );

  evtcnt_datapath #(.NUM_CNT(NUM_CNT), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .ptrAddr  (ptrAddr),
    .ptrHigh  (ptrHigh),
    .evt      (evtStrobe),
    .dataWord (dataWord)
  );

  always_comb begin
    unique case (regAddr)
      REG_STAT: regRdata = statusWord;
      REG_DATA: regRdata = dataWord;
      default:  regRdata = '0;
    endcase
  end

endmodule

// File: tb/sim_evtcnt_bank.sv
module sim_evtcnt_bank;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic        regRe = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [15:0] regWdata = 16'd0;
  logic [15:0] regRdata;
  logic [31:0] evtStrobe = '0;

  int checks = 0;
  int errors = 0;
  logic [15:0] rd;

  // model of counter 0 for the carry test
  logic        mRun = 1'b0;
  logic [31:0] mCnt = '0;

  always #10 clk = ~clk;

  evtcnt_bank u0 (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .evtStrobe(evtStrobe)
  );

  always @(posedge clk) begin
    if (regWe && regAddr == 2'd0 && regWdata[1:0] == 2'b00) mCnt <= '0;
    else if (mRun && evtStrobe[0]) mCnt <= mCnt + 1;
    if (regWe && regAddr == 2'd0 && regWdata[1:0] == 2'b01) mRun <= 1'b1;
    if (regWe && regAddr == 2'd0 && regWdata[1:0] == 2'b10) mRun <= 1'b0;
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all tasks start right after a falling edge
  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [15:0] d);
    regRe = (a == 2'd2); regAddr = a;
    #2 d = regRdata;
    @(negedge clk);
    regRe = 1'b0;
  endtask

  function automatic logic [15:0] loa(input int idx, input bit ainc);
    return {8'd0, ainc, idx[4:0], 2'b11};
  endfunction

  task automatic pulse(input int idx, input int n);
    for (int k = 0; k < n; k++) begin
      evtStrobe[idx] = 1'b1;
      @(negedge clk);
      evtStrobe[idx] = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    rdReg(2'd1, rd); chk("R1 status after reset", rd, 16'h0000);
    wr(2'd0, loa(0, 1));
    for (int k = 0; k < 4; k++) begin
      rdReg(2'd2, rd); chk("R1 counter zero after reset", rd, 16'h0000);
    end
  endtask

  task automatic t_count;
    wr(2'd0, 16'h0000);
    pulse(3, 2);                       // stopped: ignored
    wr(2'd0, 16'h0001);
    pulse(3, 5);
    evtStrobe[7] = 1'b1; evtStrobe[3] = 1'b1;
    @(negedge clk); @(negedge clk);    // two strobe cycles
    evtStrobe = '0;
    wr(2'd0, 16'h0002);
    pulse(3, 4);                       // stopped: ignored
    wr(2'd0, loa(3, 1));
    rdReg(2'd1, rd); chk("R5 status after load", rd, 16'h0043);
    rdReg(2'd2, rd); chk("R3 counter3 low", rd, 16'd7);
    rdReg(2'd1, rd); chk("R7 status after low read", rd, 16'h0063);
    rdReg(2'd2, rd); chk("R6 counter3 high", rd, 16'd0);
    rdReg(2'd1, rd); chk("R7 status moves to next counter", rd, 16'h0044);
    rdReg(2'd2, rd); chk("R7 counter4 low", rd, 16'd0);
    wr(2'd0, loa(7, 1));
    rdReg(2'd2, rd); chk("R2 counter7 low", rd, 16'd2);
  endtask

  task automatic t_clear_running;
    wr(2'd0, 16'h0001);
    pulse(5, 3);
    wr(2'd0, 16'h0000);
    pulse(5, 2);
    wr(2'd0, 16'h0002);
    wr(2'd0, loa(5, 0));
    rdReg(2'd2, rd); chk("R4 counts from zero while running", rd, 16'd2);
    wr(2'd0, loa(3, 1));
    rdReg(2'd2, rd); chk("R4 other counter cleared", rd, 16'd0);
  endtask

  task automatic t_no_step;
    wr(2'd0, 16'h0001);
    pulse(9, 6);
    wr(2'd0, 16'h0002);
    wr(2'd0, loa(9, 0));
    for (int k = 0; k < 3; k++) begin
      rdReg(2'd2, rd); chk("R8 same word repeated", rd, 16'd6);
    end
    rdReg(2'd1, rd); chk("R8 pointer unmoved", rd, 16'h0009);
  endtask

  task automatic t_wrap;
    wr(2'd0, loa(31, 1));
    rdReg(2'd2, rd);
    rdReg(2'd2, rd);
    rdReg(2'd1, rd); chk("R10 pointer wraps to counter 0", rd, 16'h0040);
  endtask

  task automatic t_carry;
    logic [15:0] lo;
    wr(2'd0, 16'h0000);
    wr(2'd0, loa(0, 1));
    evtStrobe[0] = 1'b1;
    wr(2'd0, 16'h0001);
    while (mCnt != 32'h0000_FFFF) @(negedge clk);
    rdReg(2'd2, lo); chk("R9 low half at carry point", lo, 16'hFFFF);
    rdReg(2'd2, rd); chk("R9 high half frozen at low read", rd, 16'h0000);
    rdReg(2'd2, rd); chk("R9 next counter low", rd, 16'h0000);
    evtStrobe[0] = 1'b0;
    wr(2'd0, 16'h0002);
    @(negedge clk);
    wr(2'd0, loa(0, 1));
    rdReg(2'd2, lo); chk("R6 stopped low half", lo, mCnt[15:0]);
    rdReg(2'd2, rd); chk("R6 stopped high half", rd, mCnt[31:16]);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rstN = 1'b1;
        @(negedge clk);
        t_reset();
        t_count();
        t_clear_running();
        t_no_step();
        t_wrap();
        t_carry();
      end
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule